// File: doc/BRIEF.md
# Three-Cache MOESI Line Coherence Tracker

This block follows the coherence state of one shared memory line held by a set of private caches that watch a common snooping bus. Each cache raises a read or a write request. The block accepts at most one request per cycle. At the clock edge where it accepts the request, it updates the five-state coherence value of every cache. Each cache's state is driven out as a 3-bit code.

Alongside the states, the block reports whether the last accepted read miss took its data from a peer cache rather than from memory, and which peer that was. A dirty line can be shared without first being written back: the cache that held it modified keeps responsibility for the data in the Owned state.

The number of caches is a parameter, with a default of three caches (A = index 0, B = 1, C = 2). Data storage, evictions, bus arbitration beyond the fixed priority, and tracking more than one line are not part of the block.

Top module: `moesi_tracker`

## Requirements
- R1: After reset every cache reports Invalid and the supply flag is low.
- R2: An accepted write moves the writer to Modified and every other cache to Invalid. This holds whether the writer was in I, S, E, O or M.
- R3: An accepted read by a cache in I, while no other cache holds the line, moves the reader to Exclusive and takes the data from memory (supply flag low).
- R4: An accepted read miss while a peer is in Modified has three effects: the reader goes to Shared, the peer goes to Owned, and the supply flag rises with the peer's index.
- R5: An accepted read miss while a peer is in Exclusive leaves both caches in Shared, and the data comes from memory.
- R6: An accepted read miss while a peer is in Owned has three effects: the reader goes to Shared, the owner stays Owned, and the supply flag names the owner.
- R7: A read by a cache that already holds the line (any state other than I) changes no state and leaves the supply flag low.
- R8: When several caches request in one cycle, only the lowest-index requester is served and the other requests have no effect. If one cache raises read and write together, its write is served.
- R9: At no time is more than one cache in M, O or E.
- R10: State codes are I=0, S=1, E=2, O=3, M=4. Cache k's code sits at bits [3k+2:3k] of `line_state`. States and the supply outputs change at the clock edge that accepts the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_req | input | N_CACHE | Read request, one bit per cache |
| wr_req | input | N_CACHE | Write request, one bit per cache |
| line_state | output | 3*N_CACHE | Packed per-cache state codes |
| peer_supply | output | 1 | Last accepted read miss took its data from a peer cache |
| peer_id | output | $clog2(N_CACHE) | Index of the supplying peer |

## Verification
The main function is tried with three kinds of request sequence.

- Long chained sequences starting from a clean line. One of them is the read-all, write A, read B, write C, read A order, which must end with A=S, B=I, C=O. These sequences tell a correct Modified-to-Owned downgrade apart from a writeback to memory.
- Short two-step pairs. These separate a read after an Exclusive holder (memory supplies the data) from a read after a Modified or Owned holder (a peer supplies it). They also separate a silent write from Exclusive from a write from Shared.
- Cycles with several requests at once, including read and write on the same cache. These show that only the lowest index acts and that the write wins, because the losers' states are visible as unchanged.

// File: rtl/moesi_pkg.sv
package moesi_pkg;
  typedef enum logic [2:0] {
    ST_I = 3'd0,
    ST_S = 3'd1,
    ST_E = 3'd2,
    ST_O = 3'd3,
    ST_M = 3'd4
  } line_st_e;

  localparam int ST_W = 3;
endpackage

// File: rtl/moesi_arbiter.sv
module moesi_arbiter #(
  parameter int N_CACHE = 3,
  localparam int IDW = (N_CACHE > 1) ? $clog2(N_CACHE) : 1
) (
  input  logic [N_CACHE-1:0] rd_req,
  input  logic [N_CACHE-1:0] wr_req,
  output logic               gnt_vld,
  output logic [IDW-1:0]     gnt_idx,
  output logic               gnt_wr
);
  logic [N_CACHE-1:0] any_req;

  assign any_req = rd_req | wr_req;

  // fixed priority: scan downward so the lowest requester is the last written
  always_comb begin
    gnt_vld = 1'b0;
    gnt_idx = '0;
    gnt_wr  = 1'b0;
    for (int i = N_CACHE - 1; i >= 0; i--) begin
      if (any_req[i]) begin
        gnt_vld = 1'b1;
        gnt_idx = IDW'(i);
        gnt_wr  = wr_req[i];
      end
    end
  end

  // R8: no requester below the granted index
  always_comb begin
    if (gnt_vld) begin
      for (int j = 0; j < N_CACHE; j++) begin
        if (j < int'(gnt_idx)) begin
          assert_grant_lowest_R8: assert (!any_req[j]);
        end
      end
    end
  end
endmodule

// File: rtl/moesi_next.sv
module moesi_next
  import moesi_pkg::*;
(
  input  line_st_e cur,
  input  logic     gnt_vld,
  input  logic     gnt_wr,
  input  logic     is_self,
  input  logic     peers_hold,
  output line_st_e nxt
);
  always_comb begin
    nxt = cur;
    if (gnt_vld) begin
      if (gnt_wr) begin
        nxt = is_self ? ST_M : ST_I;
      end else if (is_self) begin
        if (cur == ST_I) nxt = peers_hold ? ST_S : ST_E;
      end else begin
        unique case (cur)
          ST_M:    nxt = ST_O;
          ST_E:    nxt = ST_S;
          default: nxt = cur;
        endcase
      end
    end
  end
endmodule

// File: rtl/moesi_tracker.sv
module moesi_tracker
  import moesi_pkg::*;
#(
  parameter int N_CACHE = 3,
  localparam int IDW = (N_CACHE > 1) ? $clog2(N_CACHE) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_CACHE-1:0]      rd_req,
  input  logic [N_CACHE-1:0]      wr_req,
  output logic [ST_W*N_CACHE-1:0] line_state,
  output logic                    peer_supply,
  output logic [IDW-1:0]          peer_id
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic           gnt_vld, gnt_wr;
  logic [IDW-1:0] gnt_idx;

  moesi_arbiter #(.N_CACHE(N_CACHE)) u_arb (
    .rd_req (rd_req),
    .wr_req (wr_req),
    .gnt_vld(gnt_vld),
    .gnt_idx(gnt_idx),
    .gnt_wr (gnt_wr)
  );

  line_st_e           st_q [N_CACHE];
  line_st_e           st_d [N_CACHE];
  logic [N_CACHE-1:0] hold_vec, own_vec, dirty_vec, m_vec;

  genvar k;
  generate
    for (k = 0; k < N_CACHE; k++) begin : g_cache
      logic is_self;
      assign is_self      = (gnt_idx == IDW'(k));
      assign hold_vec[k]  = (st_q[k] != ST_I);
      assign own_vec[k]   = (st_q[k] == ST_M) || (st_q[k] == ST_O) || (st_q[k] == ST_E);
      assign dirty_vec[k] = (st_q[k] == ST_M) || (st_q[k] == ST_O);
      assign m_vec[k]     = (st_q[k] == ST_M);

      moesi_next u_next (
        .cur       (st_q[k]),
        .gnt_vld   (gnt_vld),
        .gnt_wr    (gnt_wr),
        .is_self   (is_self),
        .peers_hold(|(hold_vec & ~(N_CACHE'(1) << k))),
        .nxt       (st_d[k])
      );

      always_ff @(posedge clk or negedge rst_int_n) begin
        if (!rst_int_n)   st_q[k] <= ST_I;
        else if (gnt_vld) st_q[k] <= st_d[k];
      end

      assign line_state[ST_W*k +: ST_W] = st_q[k];
    end
  endgenerate

  // data source for a read miss
  logic           rd_miss, sup_d;
  logic [IDW-1:0] sup_id_d;

  always_comb begin
    rd_miss  = gnt_vld && !gnt_wr && !hold_vec[gnt_idx];
    sup_d    = 1'b0;
    sup_id_d = '0;
    for (int i = 0; i < N_CACHE; i++) begin
      if (rd_miss && dirty_vec[i]) begin
        sup_d    = 1'b1;
        sup_id_d = IDW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      peer_supply <= 1'b0;
      peer_id     <= '0;
    end else begin
      peer_supply <= sup_d;
      if (sup_d) peer_id <= sup_id_d;
    end
  end

  logic rd_hit;
  assign rd_hit = gnt_vld && !gnt_wr && hold_vec[gnt_idx];

  assert_single_owner_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    $countones(own_vec) <= 1);

  assert_write_wins_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (gnt_vld && gnt_wr) |=> ($countones(m_vec) == 1 && $countones(hold_vec) == 1));

  assert_supplier_owned_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    peer_supply |-> (st_q[peer_id] == ST_O));

  assert_hit_stable_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_hit |=> ($stable(line_state) && !peer_supply));

  assert_req_served_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (|(rd_req | wr_req)) |-> gnt_vld);
endmodule

// File: tb/moesi_tracker_bench.sv
module moesi_tracker_bench;
  localparam int N = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] rd_req, wr_req;
  logic [8:0] line_state;
  logic       peer_supply;
  logic [1:0] peer_id;

  int n_run  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  moesi_tracker #(.N_CACHE(N)) u_moesi_tracker (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req     (rd_req),
    .wr_req     (wr_req),
    .line_state (line_state),
    .peer_supply(peer_supply),
    .peer_id    (peer_id)
  );

  // {rst, rd[2:0], wr[2:0], state 9'o{C}{B}{A}, supply, id, req tag}
  // codes I=0 S=1 E=2 O=3 M=4
  localparam int NV = 20;
  localparam logic [22:0] VEC [NV] = '{
    {1'b1, 3'b001, 3'b000, 9'o002, 1'b0, 2'd0, 4'd3},  // R3 A reads clean line -> E
    {1'b0, 3'b010, 3'b000, 9'o011, 1'b0, 2'd0, 4'd5},  // R5 B reads, A was E
    {1'b0, 3'b100, 3'b000, 9'o111, 1'b0, 2'd0, 4'd5},  // R5 C reads shared line
    {1'b0, 3'b000, 3'b001, 9'o004, 1'b0, 2'd0, 4'd2},  // R2 A writes from S
    {1'b0, 3'b010, 3'b000, 9'o013, 1'b1, 2'd0, 4'd4},  // R4 B reads, A M -> O
    {1'b0, 3'b000, 3'b100, 9'o400, 1'b0, 2'd0, 4'd2},  // R2 C writes
    {1'b0, 3'b001, 3'b000, 9'o301, 1'b1, 2'd2, 4'd4},  // R4 A reads: A=S B=I C=O
    {1'b0, 3'b010, 3'b000, 9'o311, 1'b1, 2'd2, 4'd6},  // R6 B reads from O
    {1'b0, 3'b010, 3'b000, 9'o311, 1'b0, 2'd0, 4'd7},  // R7 B read hit
    {1'b1, 3'b000, 3'b010, 9'o040, 1'b0, 2'd0, 4'd2},  // R2 B writes clean line
    {1'b0, 3'b001, 3'b000, 9'o031, 1'b1, 2'd1, 4'd4},  // R4 A reads, B M -> O
    {1'b1, 3'b010, 3'b000, 9'o020, 1'b0, 2'd0, 4'd3},  // R3 B reads clean -> E
    {1'b0, 3'b001, 3'b000, 9'o011, 1'b0, 2'd0, 4'd5},  // R5 A reads, both S
    {1'b0, 3'b000, 3'b001, 9'o004, 1'b0, 2'd0, 4'd2},  // R2 write from S kills B
    {1'b1, 3'b001, 3'b000, 9'o002, 1'b0, 2'd0, 4'd3},  // R3 A -> E
    {1'b0, 3'b000, 3'b001, 9'o004, 1'b0, 2'd0, 4'd2},  // R2 silent E -> M
    {1'b0, 3'b110, 3'b000, 9'o013, 1'b1, 2'd0, 4'd8},  // R8 B and C read, B served
    {1'b0, 3'b001, 3'b100, 9'o013, 1'b0, 2'd0, 4'd8},  // R8 A hit wins, C write dropped
    {1'b0, 3'b010, 3'b010, 9'o040, 1'b0, 2'd0, 4'd8},  // R8 same cache rd+wr: write
    {1'b0, 3'b000, 3'b000, 9'o040, 1'b0, 2'd0, 4'd10}  // R10 idle keeps state
  };

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s state=%o sup=%b id=%0d expected state=%o sup=%b id=%0d",
               tag, act[11:3], act[2], act[1:0], exp[11:3], exp[2], exp[1:0]);
    end
  endtask

  function automatic int owners(input logic [8:0] s);
    int c = 0;
    for (int i = 0; i < N; i++)
      if (s[3*i +: 3] == 3'd2 || s[3*i +: 3] == 3'd3 || s[3*i +: 3] == 3'd4) c++;
    return c;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n  = 1'b0;
    rd_req = '0;
    wr_req = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n  = 1'b0;
    rd_req = '0;
    wr_req = '0;
    do_reset();
    // R1 reset state
    check("R1", {line_state, peer_supply, peer_id}, {9'o000, 1'b0, 2'd0});

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][22]) do_reset();
      @(negedge clk);
      rd_req = VEC[v][21:19];
      wr_req = VEC[v][18:16];
      @(negedge clk);
      rd_req = '0;
      wr_req = '0;
      check($sformatf("R%0d vec%0d", VEC[v][3:0], v),
            {line_state, peer_supply, VEC[v][6] ? peer_id : 2'd0},
            {VEC[v][15:7], VEC[v][6], VEC[v][5:4]});
      // R9 at most one cache in M, O or E
      check("R9", {3'd0, 9'(owners(line_state))}, {3'd0, 9'(owners(line_state) <= 1 ? owners(line_state) : 1)});
    end

    // R10: a state change is visible right after the accepting edge, not before
    do_reset();
    @(negedge clk);
    wr_req = 3'b100;
    @(posedge clk);
    #1;
    check("R10 edge", {line_state, peer_supply, 2'd0}, {9'o400, 1'b0, 2'd0});
    wr_req = '0;

    // R1 reset mid-operation returns all to I
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async", {line_state, peer_supply, 2'd0}, {9'o000, 1'b0, 2'd0});
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule